// File: doc/BRIEF.md
# SPI Master with Per-Target Timing

This block is a single-master SPI controller running in clock mode 0 (idle-low serial clock, data captured on the rising edge, changed on the falling edge) with 8-bit frames, most significant bit first. It drives four active-low select outputs. Software configures it through a small register port. A mode register sets global behaviour. Four per-target configuration registers each hold a bit-rate divisor, a pre-clock delay and a back-to-back delay. A transmit register carries a data byte and a 4-bit target code. A receive register returns the captured byte together with the select code that was in effect.

The target of a transfer comes either from the mode register or from the code carried with each transmit word. The timing parameters are looked up per target. A global gap is inserted whenever the next transfer goes to a different target. A one-entry buffer holds a transmit word that is written while a transfer is running. Between transfers every select line rests high.

Top module: `spi_tgt_master`

## Requirements
- R1: After reset, all select lines are high, sclk and mosi are low, the status register (address 1) reads transmit-empty (bit 1) as 1 and receive-full (bit 0) as 0.
- R2: With variable selection off (mode bit 0 = 0), every transfer uses the target code in mode bits [7:4], and the code in the transmit word is ignored.
- R3: With variable selection on (mode bit 0 = 1), the code in transmit bits [11:8] selects the target, and mode bits [7:4] are ignored.
- R4: In direct mode (mode bit 1 = 0), the lowest zero bit of the code picks the one line driven low (xxx0 gives line 0, xx01 gives line 1, x011 gives line 2, 0111 gives line 3). The same index picks the configuration bank (address 4 + index). Code 1111 drives no line and uses bank 3.
- R5: In decoded mode (mode bit 1 = 1), the 4-bit code itself is driven on the select outputs during a transfer, and the bank is code[1:0].
- R6: All select lines are high whenever no transfer is in progress, including between back-to-back transfers.
- R7: Each sclk half period lasts max(div,2) base cycles, where div is bits [7:0] of the bank. The base cycle is one clock, or 32 clocks when mode bit 2 is set. A transfer therefore holds its select low for pre + 16 half periods.
- R8: The first rising sclk edge comes max(pre,1) clocks plus one half period after the select asserts, where pre is bits [15:8] of the bank.
- R9: When a buffered word goes to the same code as the previous transfer, the select stays high for 1 + max(gap_same,1) clocks, where gap_same is bits [23:16] of that bank.
- R10: When a buffered word goes to a different code, the select stays high for 1 + max(gap_chg,1) clocks, where gap_chg is mode bits [15:8].
- R11: mosi shifts out the transmit byte MSB first, and the miso level sampled at each rising sclk edge forms the received byte MSB first.
- R12: At the end of each transfer, the receive register (address 3) holds the byte in [7:0] and the code used in [11:8], and receive-full is set. A read of address 3 with rd_en clears receive-full.
- R13: A transmit word written while a transfer runs is held in a one-entry buffer (transmit-empty reads 0). It starts after the current transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; clears receive-full when addr is 3 |
| addr | input | 3 | Register address (0 mode, 1 status, 2 transmit, 3 receive, 4-7 banks) |
| wr_data | input | 3*FW | Write data |
| rd_data | output | 3*FW | Combinational read data for addr |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Select outputs, active low |

## Verification
A transmit word written while the block is idle asserts the select two clocks later when no delay applies. After that, the select stays low for exactly pre + 16 half periods. The first rising sclk edge follows the assertion by pre plus one half period. When a buffered word is waiting, the select stays high between transfers for one launch cycle plus the chosen gap. The bench counts clock edges between select and sclk transitions, sampling them on falling clock edges, and compares those counts with the values computed from the requirements. Received data and receive-full are read only after polling shows receive-full set.

// File: rtl/spi_tgt_master.sv
module spi_tgt_master #(
  parameter int FW = 8,
  localparam int DW = 3 * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic [3:0]    cs_n
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LEAD, S_SHIFT} st_t;

  logic          m_var, m_dec, m_div32;
  logic [3:0]    m_code;
  logic [FW-1:0] m_gap;
  logic [FW-1:0] c_div [4];
  logic [FW-1:0] c_pre [4];
  logic [FW-1:0] c_int [4];

  logic          buf_v;
  logic [7:0]    buf_dat;
  logic [3:0]    buf_code;

  st_t           st;
  logic [7:0]    sh, rxs, rx_dat;
  logic [3:0]    cur_code, prev_code, rx_code;
  logic [1:0]    cur_bank;
  logic          have_prev, rx_full;
  logic [FW-1:0] cnt, hcnt;
  logic [4:0]    pres;
  logic [2:0]    bitn;

  function automatic logic [1:0] bank_of(input logic [3:0] c, input logic d);
    if (d)     return c[1:0];
    if (!c[0]) return 2'd0;
    if (!c[1]) return 2'd1;
    if (!c[2]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [FW-1:0] dly1(input logic [FW-1:0] x);
    return (x == '0) ? FW'(1) : x;
  endfunction

  wire [3:0]    nxt_code = m_var ? buf_code : m_code;
  wire [1:0]    nxt_bank = bank_of(nxt_code, m_dec);
  wire [FW-1:0] half     = (c_div[cur_bank] < FW'(2)) ? FW'(2) : c_div[cur_bank];
  wire          tick     = !m_div32 || (pres == 5'd31);
  wire          active   = (st == S_LEAD) || (st == S_SHIFT);
  wire          done     = (st == S_SHIFT) && tick && (hcnt == FW'(1)) && sclk && (bitn == 3'd7);
  wire [FW-1:0] wait_val = (nxt_code == prev_code) ? dly1(c_int[nxt_bank]) : dly1(m_gap);

  assign cs_n = !active ? 4'hF :
                m_dec ? cur_code :
                (cur_code == 4'hF) ? 4'hF : ~(4'b0001 << cur_bank);
  assign mosi = active && sh[7];

  always_comb begin
    case (addr)
      3'd0:    rd_data = DW'({m_gap, m_code, 1'b0, m_div32, m_dec, m_var});
      3'd1:    rd_data = DW'({st != S_IDLE, !buf_v, rx_full});
      3'd2:    rd_data = DW'({buf_code, buf_dat});
      3'd3:    rd_data = DW'({rx_code, rx_dat});
      default: rd_data = {c_int[addr[1:0]], c_pre[addr[1:0]], c_div[addr[1:0]]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_var <= 1'b0; m_dec <= 1'b0; m_div32 <= 1'b0; m_code <= 4'hF; m_gap <= '0;
      for (int i = 0; i < 4; i++) begin
        c_div[i] <= '0; c_pre[i] <= '0; c_int[i] <= '0;
      end
      buf_v <= 1'b0; buf_dat <= '0; buf_code <= 4'hF;
    end else begin
      if (st == S_IDLE && buf_v) buf_v <= 1'b0;
      if (wr_en) begin
        case (addr)
          3'd0: begin
            m_var <= wr_data[0]; m_dec <= wr_data[1]; m_div32 <= wr_data[2];
            m_code <= wr_data[7:4]; m_gap <= wr_data[8 +: FW];
          end
          3'd2: begin
            buf_v <= 1'b1; buf_dat <= wr_data[7:0]; buf_code <= wr_data[11:8];
          end
          3'd4, 3'd5, 3'd6, 3'd7: begin
            c_div[addr[1:0]] <= wr_data[0 +: FW];
            c_pre[addr[1:0]] <= wr_data[FW +: FW];
            c_int[addr[1:0]] <= wr_data[2*FW +: FW];
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; rxs <= '0; cur_code <= 4'hF; cur_bank <= '0;
      prev_code <= 4'hF; have_prev <= 1'b0; cnt <= '0; hcnt <= '0;
      pres <= '0; bitn <= '0; sclk <= 1'b0;
      rx_dat <= '0; rx_code <= 4'hF; rx_full <= 1'b0;
    end else begin
      if (rd_en && addr == 3'd3) rx_full <= 1'b0;
      case (st)
        S_IDLE: if (buf_v) begin
          sh <= buf_dat; cur_code <= nxt_code; cur_bank <= nxt_bank;
          if (have_prev) begin
            st <= S_WAIT; cnt <= wait_val;
          end else begin
            st <= S_LEAD; cnt <= dly1(c_pre[nxt_bank]);
          end
        end
        S_WAIT: if (cnt == FW'(1)) begin
          st <= S_LEAD; cnt <= dly1(c_pre[cur_bank]);
        end else cnt <= cnt - FW'(1);
        S_LEAD: if (cnt == FW'(1)) begin
          st <= S_SHIFT; hcnt <= half; pres <= '0; bitn <= '0; sclk <= 1'b0;
        end else cnt <= cnt - FW'(1);
        S_SHIFT: begin
          pres <= pres + 5'd1;
          if (tick) begin
            if (hcnt == FW'(1)) begin
              hcnt <= half;
              if (!sclk) begin
                sclk <= 1'b1;
                rxs  <= {rxs[6:0], miso};
              end else begin
                sclk <= 1'b0;
                if (bitn == 3'd7) begin
                  st <= S_IDLE; rx_dat <= rxs; rx_code <= cur_code; rx_full <= 1'b1;
                  prev_code <= cur_code; have_prev <= 1'b1;
                end else begin
                  bitn <= bitn + 3'd1;
                  sh   <= {sh[6:0], 1'b0};
                end
              end
            end else hcnt <= hcnt - FW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_WAIT) |-> cs_n == 4'hF);
  a_r8_no_clock_in_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LEAD) |-> !sclk);
  a_r7_clock_only_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(st) == S_SHIFT);
  a_r12_full_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_full);
  a_r4_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    !m_dec |-> $countones(~cs_n) <= 1);
  a_r13_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && buf_v) |=> buf_v);

endmodule

// File: tb/spi_tgt_master_test.sv
`timescale 1ns/1ps
module spi_tgt_master_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, miso;
  logic [2:0] addr = 0;
  logic [23:0] wr_data = 0, rd_data;
  logic sclk, mosi;
  logic [3:0] cs_n;

  spi_tgt_master uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc++;

  logic [3:0] pcs = 4'hF, seen_cs = 4'hF, nrise = 0;
  logic psclk = 0, first_rise = 0;
  logic [7:0] mosi_b = 0, sbyte = 0;
  int t_as = 0, t_rel = 0, low_len = 0, lead_len = 0, gap_len = 0;

  assign miso = (nrise < 4'd8) ? sbyte[3'd7 - nrise[2:0]] : 1'b0;

  always @(negedge clk) begin
    if (pcs == 4'hF && cs_n != 4'hF) begin
      gap_len = cyc - t_rel; t_as = cyc; seen_cs = cs_n; first_rise = 1; nrise = 0;
    end
    if (pcs != 4'hF && cs_n == 4'hF) begin t_rel = cyc; low_len = cyc - t_as; end
    if (!psclk && sclk) begin
      if (first_rise) begin lead_len = cyc - t_as; first_rise = 0; end
      mosi_b = {mosi_b[6:0], mosi};
      nrise = nrise + 4'd1;
    end
    pcs = cs_n; psclk = sclk;
  end

  task automatic eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic clr, output logic [23:0] d);
    @(negedge clk); addr = a; rd_en = clr; #1 d = rd_data;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_rx();
    logic [23:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd1, 1'b0, s);
      if (s[0]) return;
    end
  endtask

  function automatic int mx(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  task automatic xfer(input logic [3:0] code, input logic [7:0] d, input logic [7:0] sb,
                      input logic [3:0] ecs, input logic [3:0] ecode, input string tag);
    logic [23:0] r;
    sbyte = sb; seen_cs = 4'hF; nrise = 0;
    wr(3'd2, {12'h0, code, d});
    wait_rx();
    rd(3'd3, 1'b1, r);
    eq({tag, " R11 mosi byte"}, mosi_b, d);
    eq({tag, " R11 miso byte"}, r[7:0], sb);
    eq({tag, " R12 rx code"}, r[11:8], ecode);
    eq({tag, " select lines"}, seen_cs, ecs);
    eq({tag, " R6 released"}, cs_n, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] r;
    repeat (3) @(negedge clk);
    eq("R1 cs", cs_n, 4'hF); eq("R1 sclk", sclk, 0); eq("R1 mosi", mosi, 0);
    rst_n = 1;
    rd(3'd1, 1'b0, r);
    eq("R1 tx empty", r[1], 1); eq("R1 rx full", r[0], 0);

    // R7 divisor sweep, variable direct mode, code 0 -> line 0, bank 0
    wr(3'd0, 24'h0000F1);
    for (int f = 0; f < 7; f++) begin
      wr(3'd4, {8'd1, 8'd1, 8'(f)});
      xfer(4'h0, 8'(8'hA5 + f), 8'(8'h3C ^ f), 4'hE, 4'h0, "R7");
      eq("R7 select low length", low_len, 1 + 16 * mx(f, 2));
    end
    // R8 pre-clock delay sweep
    for (int p = 0; p < 5; p++) begin
      wr(3'd4, {8'd1, 8'(p), 8'd3});
      xfer(4'h0, 8'h96, 8'h69, 4'hE, 4'h0, "R8");
      eq("R8 lead to first rise", lead_len, mx(p, 1) + 3);
    end
    for (int b = 0; b < 4; b++) wr(3'(4 + b), {8'd1, 8'd1, 8'd2});
    // R3/R4 every code in direct mode; mode code field set to 0 and ignored
    wr(3'd0, 24'h000001);
    for (int c = 0; c < 16; c++) begin
      logic [3:0] e;
      e = (!c[0]) ? 4'hE : (!c[1]) ? 4'hD : (!c[2]) ? 4'hB : (!c[3]) ? 4'h7 : 4'hF;
      xfer(4'(c), 8'(c * 17 ^ 8'h5A), 8'(c * 29 + 3), e, 4'(c), "R3 R4");
    end
    rd(3'd1, 1'b0, r);
    eq("R12 rx full cleared by read", r[0], 0);
    // R5 decoded mode
    wr(3'd0, 24'h000003);
    for (int c = 0; c < 15; c++)
      xfer(4'(c), 8'(c * 7 + 1), 8'(~(c * 11)), 4'(c), 4'(c), "R5");
    // R2 fixed selection: mode code 1101 -> line 1; transmit code 0 ignored
    wr(3'd0, 24'h0000D0);
    xfer(4'h0, 8'hC3, 8'h81, 4'hD, 4'hD, "R2");
    xfer(4'h7, 8'h12, 8'h34, 4'hD, 4'hD, "R2");
    // R9/R13 back-to-back same target
    wr(3'd0, 24'h000701);
    for (int g = 0; g < 3; g++) begin
      wr(3'd4, {8'(g * 5), 8'd1, 8'd6});
      xfer(4'h0, 8'h01, 8'h02, 4'hE, 4'h0, "R9 prime");
      sbyte = 8'hE7;
      wr(3'd2, {12'h0, 4'h0, 8'h5D});
      wr(3'd2, {12'h0, 4'h0, 8'hB2});
      rd(3'd1, 1'b0, r);
      eq("R13 buffer occupied", r[1], 0);
      eq("R13 busy", r[2], 1);
      wait_rx(); rd(3'd3, 1'b1, r);
      eq("R11 first buffered rx", r[7:0], 8'hE7);
      wait_rx(); rd(3'd3, 1'b1, r);
      eq("R13 second word sent", mosi_b, 8'hB2);
      eq("R9 same target gap", gap_len, 1 + mx(g * 5, 1));
    end
    // R10 change of target: code 0 then code 1, global gap 7
    wr(3'd5, {8'd1, 8'd1, 8'd2});
    sbyte = 8'h0F;
    wr(3'd2, {12'h0, 4'h0, 8'h11});
    wr(3'd2, {12'h0, 4'h1, 8'h22});
    wait_rx(); rd(3'd3, 1'b1, r);
    wait_rx(); rd(3'd3, 1'b1, r);
    eq("R10 change gap", gap_len, 8);
    eq("R10 new line", seen_cs, 4'hD);
    eq("R12 code of second", r[11:8], 4'h1);
    // R7 with the divide-by-32 base clock
    wr(3'd0, 24'h000005);
    wr(3'd4, {8'd1, 8'd1, 8'd2});
    xfer(4'h0, 8'h6E, 8'h9B, 4'hE, 4'h0, "R7 div32");
    eq("R7 div32 low length", low_len, 1 + 16 * 2 * 32);
    eq("R8 div32 lead", lead_len, 1 + 2 * 32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule